// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block narrows a 32-bit IEEE binary32 operand to a 16-bit half-precision value. It keeps the sign, rebiases the exponent, drops the 13 low fraction bits under one of four rounding modes, and raises invalid, overflow, underflow and inexact flags. When an operand is too small for the half normal range, the block shifts it into a half subnormal. The guard and sticky bits are kept exact through that shift.

A format select picks the target format. IEEE half is the default. The alternative half format has no infinities and no NaNs, so exponent code 31 holds ordinary normal numbers and results that are too large saturate to the largest magnitude. Three more controls modify the result:

- Flushing replaces binary32 subnormal inputs with a signed zero.
- Default-NaN mode replaces every NaN result with one canonical quiet NaN.
- An underflow-trap enable reports underflow for every result in the subnormal range, even when that result is exact.

The conversion logic is combinational. The result and the flags are registered once, so each result appears one clock after its operands.

Top module: `f2h_narrow`

## Requirements
- R1: A binary32 operand with biased exponent 113..142 whose 13 low fraction bits are all zero converts exactly. The output exponent field is the input exponent minus 112, the output fraction is input fraction bits 22..13, and the sign is copied. No flag is raised.
- R2: IEEE format, NaN input (exponent 255, fraction nonzero), default-NaN off: the output is the input sign, exponent field 31, fraction bit 9 set and fraction bits 8..0 taken from input fraction bits 21..13. Invalid is raised only when input fraction bit 22 is 0 (signalling NaN).
- R3: IEEE format with default-NaN on: any NaN input gives 16'h7E00. Invalid follows the same signalling rule as R2.
- R4: IEEE format, infinite input: the output is the sign with 15'h7C00 and no flag. A zero input in either format gives a signed zero and no flag, even with the underflow trap enabled.
- R5: Alternative format: a NaN input gives a signed zero with invalid. An infinite input gives the sign with 15'h7FFF and invalid. Exponent field 31 is a normal value.
- R6: An operand with biased exponent at or below 112 (and no flush) becomes a half subnormal. The value is shifted right by 113 minus the exponent, and the guard and sticky bits are kept exact.
- R7: The rounding mode code selects the rounding: 0 is nearest with ties to even, 1 rounds toward plus infinity, 2 toward minus infinity and 3 toward zero.
- R8: A rounding carry out of fraction 0x3FF clears the fraction and adds one to the exponent. This includes the step from the largest subnormal to the smallest normal.
- R9: IEEE format: a rounded exponent of 31 or more raises overflow and inexact. The result is infinity for mode 0, for mode 1 when positive and for mode 2 when negative; otherwise it is the largest finite value, 15'h7BFF.
- R10: Alternative format: a rounded exponent of 32 or more saturates to the sign with 15'h7FFF and raises invalid only. Overflow is never raised in this format.
- R11: Underflow is raised when the final exponent field is 0 and either the result is inexact or the underflow trap is enabled.
- R12: Inexact is raised whenever any discarded bit is nonzero.
- R13: With flush on, a binary32 subnormal input gives a signed zero and raises no flag.
- R14: Outputs are registered. Reset clears the result and all flags, and a result appears on the first clock edge after its operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opIn | input | 32 | binary32 operand |
| rndMode | input | 2 | Rounding mode: 0 nearest-even, 1 up, 2 down, 3 toward zero |
| altFmt | input | 1 | Select the alternative half format |
| flushEn | input | 1 | Flush binary32 subnormal inputs to zero |
| dnanEn | input | 1 | Replace NaN results with the canonical quiet NaN |
| ufTrapEn | input | 1 | Report underflow for every subnormal-range result |
| resOut | output | 16 | Half-precision result |
| flgInvalid | output | 1 | Invalid operation flag |
| flgOverflow | output | 1 | Overflow flag |
| flgUnderflow | output | 1 | Underflow flag |
| flgInexact | output | 1 | Inexact flag |

## Verification
The sweep covers every input exponent with fraction patterns that put exact ties, just-above-tie values and all-ones fractions at the 13-bit drop point and deep in the denormalising shift. Each pattern runs under all four rounding modes, both formats and both signs. A converter that folded the guard bit into sticky in the wrong order would round a subnormal tie the wrong way. One that missed the carry would leave 0x3FF+1 as fraction 0 with the old exponent. One that used the IEEE overflow threshold in the alternative format would lose the exponent-31 normal values. Operands near 65504 and 65520 test the overflow boundary against the mode-dependent choice between infinity and the largest finite value. NaN inputs with the quiet bit clear and set test the quietening, the default-NaN replacement and the invalid flag.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int IN_EW   = 8;
  localparam int IN_FW   = 23;
  localparam int OUT_EW  = 5;
  localparam int OUT_FW  = 10;
  localparam int IN_W    = 1 + IN_EW + IN_FW;
  localparam int OUT_W   = 1 + OUT_EW + OUT_FW;
  localparam int DROP_W  = IN_FW - OUT_FW;
  localparam int IN_BIAS  = (1 << (IN_EW - 1)) - 1;
  localparam int OUT_BIAS = (1 << (OUT_EW - 1)) - 1;
  localparam int REBIAS  = IN_BIAS - OUT_BIAS;
  localparam int SH_MAX  = OUT_FW + 2 + DROP_W;
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int EXT_W   = IN_FW + 1 + SH_MAX + 1;
  localparam int EH_W    = IN_EW + 1;
  localparam int EXP_TOP = (1 << OUT_EW) - 1;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_UP   = 2'd1,
    RND_DOWN = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  typedef struct packed {
    logic            isNan;
    logic            isSnan;
    logic            isInf;
    logic            isZero;
    logic            flushZero;
    logic            altMode;
    logic            defNan;
    logic [SH_W-1:0] shAmt;
    logic [EH_W-1:0] expBase;
  } cvt_strobe_t;
endpackage

// File: rtl/f2h_ctrl.sv
module f2h_ctrl
  import f2h_pkg::*;
(
  input  logic [IN_W-1:0] opIn,
  input  logic            altFmt,
  input  logic            flushEn,
  input  logic            dnanEn,
  output cvt_strobe_t     strobe
);
  logic [IN_EW-1:0] expIn;
  logic [IN_FW-1:0] fracIn;
  logic             expOnes;
  logic             expNone;
  logic             fracAny;
  logic [EH_W-1:0]  shiftNeed;

  assign expIn   = opIn[IN_W-2 -: IN_EW];
  assign fracIn  = opIn[IN_FW-1:0];
  assign expOnes = &expIn;
  assign expNone = ~|expIn;
  assign fracAny = |fracIn;

  always_comb begin
    strobe           = '0;
    strobe.isNan     = expOnes & fracAny;
    strobe.isSnan    = expOnes & fracAny & ~fracIn[IN_FW-1];
    strobe.isInf     = expOnes & ~fracAny;
    strobe.isZero    = expNone & ~fracAny;
    strobe.flushZero = expNone & fracAny & flushEn;
    strobe.altMode   = altFmt;
    strobe.defNan    = dnanEn;
    shiftNeed        = EH_W'(REBIAS + 1) - {1'b0, expIn};
    if ({1'b0, expIn} > EH_W'(REBIAS)) begin
      strobe.shAmt   = '0;
      strobe.expBase = {1'b0, expIn} - EH_W'(REBIAS);
    end else begin
      strobe.expBase = '0;
      strobe.shAmt   = (shiftNeed > EH_W'(SH_MAX)) ? SH_W'(SH_MAX)
                                                   : shiftNeed[SH_W-1:0];
    end
  end
endmodule

// File: rtl/f2h_datapath.sv
module f2h_datapath
  import f2h_pkg::*;
(
  input  logic [IN_W-1:0]  opIn,
  input  logic [1:0]       rndMode,
  input  logic             ufTrapEn,
  input  cvt_strobe_t      strobe,
  output logic [OUT_W-1:0] resNext,
  output logic             invNext,
  output logic             ovfNext,
  output logic             unfNext,
  output logic             inxNext
);
  logic              signIn;
  logic [IN_FW-1:0]  fracIn;
  logic [EXT_W-1:0]  extVal;
  logic [EXT_W-1:0]  shifted;
  logic [OUT_FW:0]   keepBits;
  logic              guardBit;
  logic              stickyBit;
  logic              lossy;
  logic              roundUp;
  logic [OUT_FW:0]   fracSum;
  logic [EH_W-1:0]   expRnd;
  logic [OUT_FW-1:0] fracRnd;
  logic              toInf;

  assign signIn    = opIn[IN_W-1];
  assign fracIn    = opIn[IN_FW-1:0];
  assign extVal    = {1'b1, fracIn, (EXT_W-IN_FW-1)'(0)};
  assign shifted   = extVal >> strobe.shAmt;
  assign keepBits  = shifted[EXT_W-1 -: OUT_FW+1];
  assign guardBit  = shifted[EXT_W-OUT_FW-2];
  assign stickyBit = |shifted[EXT_W-OUT_FW-3:0];
  assign lossy     = guardBit | stickyBit;

  always_comb begin
    unique case (rnd_e'(rndMode))
      RND_NEAR: roundUp = guardBit & (stickyBit | keepBits[0]);
      RND_UP:   roundUp = ~signIn & lossy;
      RND_DOWN: roundUp = signIn & lossy;
      default:  roundUp = 1'b0;
    endcase
  end

  assign fracSum = {1'b0, keepBits[OUT_FW-1:0]} + (OUT_FW+1)'(roundUp);
  assign fracRnd = fracSum[OUT_FW-1:0];
  assign expRnd  = strobe.expBase + EH_W'(fracSum[OUT_FW]);
  assign toInf   = (rnd_e'(rndMode) == RND_NEAR) |
                   ((rnd_e'(rndMode) == RND_UP) & ~signIn) |
                   ((rnd_e'(rndMode) == RND_DOWN) & signIn);

  always_comb begin
    resNext = '0;
    invNext = 1'b0;
    ovfNext = 1'b0;
    unfNext = 1'b0;
    inxNext = 1'b0;
    if (strobe.isNan) begin
      if (strobe.altMode) begin
        resNext = {signIn, (OUT_W-1)'(0)};
        invNext = 1'b1;
      end else begin
        invNext = strobe.isSnan;
        if (strobe.defNan)
          resNext = {1'b0, {OUT_EW{1'b1}}, 1'b1, (OUT_FW-1)'(0)};
        else
          resNext = {signIn, {OUT_EW{1'b1}}, 1'b1, fracIn[IN_FW-2 -: OUT_FW-1]};
      end
    end else if (strobe.isInf) begin
      if (strobe.altMode) begin
        resNext = {signIn, {(OUT_W-1){1'b1}}};
        invNext = 1'b1;
      end else begin
        resNext = {signIn, {OUT_EW{1'b1}}, (OUT_FW)'(0)};
      end
    end else if (strobe.isZero | strobe.flushZero) begin
      resNext = {signIn, (OUT_W-1)'(0)};
    end else if (strobe.altMode && expRnd > EH_W'(EXP_TOP)) begin
      resNext = {signIn, {(OUT_W-1){1'b1}}};
      invNext = 1'b1;
    end else if (!strobe.altMode && expRnd >= EH_W'(EXP_TOP)) begin
      ovfNext = 1'b1;
      inxNext = 1'b1;
      resNext = toInf ? {signIn, {OUT_EW{1'b1}}, (OUT_FW)'(0)}
                      : {signIn, (OUT_EW)'(EXP_TOP - 1), {OUT_FW{1'b1}}};
    end else begin
      resNext = {signIn, expRnd[OUT_EW-1:0], fracRnd};
      inxNext = lossy;
      unfNext = (expRnd == '0) & (lossy | ufTrapEn);
    end
  end
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
  import f2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] opIn,
  input  logic [1:0]  rndMode,
  input  logic        altFmt,
  input  logic        flushEn,
  input  logic        dnanEn,
  input  logic        ufTrapEn,
  output logic [15:0] resOut,
  output logic        flgInvalid,
  output logic        flgOverflow,
  output logic        flgUnderflow,
  output logic        flgInexact
);
  cvt_strobe_t      strobe;
  logic [OUT_W-1:0] resNext;
  logic             invNext;
  logic             ovfNext;
  logic             unfNext;
  logic             inxNext;

  f2h_ctrl ctrl_i (
    .opIn    (opIn),
    .altFmt  (altFmt),
    .flushEn (flushEn),
    .dnanEn  (dnanEn),
    .strobe  (strobe)
  );

  f2h_datapath dp_i (
    .opIn     (opIn),
    .rndMode  (rndMode),
    .ufTrapEn (ufTrapEn),
    .strobe   (strobe),
    .resNext  (resNext),
    .invNext  (invNext),
    .ovfNext  (ovfNext),
    .unfNext  (unfNext),
    .inxNext  (inxNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resOut       <= '0;
      flgInvalid   <= 1'b0;
      flgOverflow  <= 1'b0;
      flgUnderflow <= 1'b0;
      flgInexact   <= 1'b0;
    end else begin
      resOut       <= resNext;
      flgInvalid   <= invNext;
      flgOverflow  <= ovfNext;
      flgUnderflow <= unfNext;
      flgInexact   <= inxNext;
    end
  end
endmodule

// File: rtl/f2h_narrow_chk.sv
module f2h_narrow_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] opIn,
  input logic        altFmt,
  input logic        flushEn,
  input logic        dnanEn,
  input logic [15:0] resOut,
  input logic        flgInvalid,
  input logic        flgOverflow,
  input logic        flgUnderflow,
  input logic        flgInexact
);
  logic inNan;
  logic inInf;
  assign inNan = (opIn[30:23] == 8'hFF) && (opIn[22:0] != 23'd0);
  assign inInf = (opIn[30:23] == 8'hFF) && (opIn[22:0] == 23'd0);

  // R10
  alt_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    altFmt |=> !flgOverflow);

  // R4
  ieee_inf_chk: assert property (@(posedge clk) disable iff (rst)
    (!altFmt && inInf) |=> (resOut[14:0] == 15'h7C00 && !flgInvalid &&
                            !flgOverflow && !flgUnderflow && !flgInexact));

  // R13
  flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flushEn && opIn[30:23] == 8'd0) |=> (resOut[14:0] == 15'd0 &&
                                          !flgInexact && !flgUnderflow));

  // R3
  default_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (!altFmt && dnanEn && inNan) |=> resOut == 16'h7E00);

  // R9
  overflow_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    flgOverflow |-> (flgInexact && !flgUnderflow));

  // R1
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (opIn[30:23] != 8'hFF) |=> resOut[15] == $past(opIn[31]));
endmodule

bind f2h_narrow f2h_narrow_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .opIn         (opIn),
  .altFmt       (altFmt),
  .flushEn      (flushEn),
  .dnanEn       (dnanEn),
  .resOut       (resOut),
  .flgInvalid   (flgInvalid),
  .flgOverflow  (flgOverflow),
  .flgUnderflow (flgUnderflow),
  .flgInexact   (flgInexact)
);

// File: tb/f2h_narrow_test.sv
`timescale 1ns/1ps
module f2h_narrow_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opIn = '0;
  logic [1:0]  rndMode = '0;
  logic        altFmt = 1'b0;
  logic        flushEn = 1'b0;
  logic        dnanEn = 1'b0;
  logic        ufTrapEn = 1'b0;
  logic [15:0] resOut;
  logic        flgInvalid, flgOverflow, flgUnderflow, flgInexact;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  f2h_narrow uut (
    .clk(clk), .rst(rst), .opIn(opIn), .rndMode(rndMode), .altFmt(altFmt),
    .flushEn(flushEn), .dnanEn(dnanEn), .ufTrapEn(ufTrapEn), .resOut(resOut),
    .flgInvalid(flgInvalid), .flgOverflow(flgOverflow),
    .flgUnderflow(flgUnderflow), .flgInexact(flgInexact)
  );

  // Arithmetic reference: value = S * 2^(e-150), quantum chosen from the half range.
  task automatic model(input logic [31:0] x, input logic [1:0] rm, input logic alt,
                       input logic fl, input logic dn, input logic ut,
                       output logic [19:0] expv, output int tag);
    logic s, inv, ovf, unf, inx, up;
    logic [7:0] e;
    logic [22:0] f;
    logic [15:0] r;
    longint sig, kept, rem, half;
    int d, eh, fr;
    s = x[31]; e = x[30:23]; f = x[22:0];
    inv = 0; ovf = 0; unf = 0; inx = 0; r = '0; tag = 1;
    if (e == 8'hFF && f != 0) begin
      if (alt) begin r = {s, 15'h0}; inv = 1; tag = 5; end       // R5
      else begin
        inv = ~f[22];
        r = dn ? 16'h7E00 : {s, 5'h1F, 1'b1, f[21:13]};
        tag = dn ? 3 : 2;                                          // R2 R3
      end
    end else if (e == 8'hFF) begin
      if (alt) begin r = {s, 15'h7FFF}; inv = 1; tag = 5; end
      else begin r = {s, 15'h7C00}; tag = 4; end                   // R4
    end else if (e == 0 && f == 0) begin
      r = {s, 15'h0}; tag = 4;
    end else if (e == 0 && fl) begin
      r = {s, 15'h0}; tag = 13;                                    // R13
    end else begin
      sig = (e == 0) ? longint'(f) : (longint'(1) << 23) + longint'(f);
      d = (e >= 113) ? 13 : 13 + 113 - int'(e);                    // R6
      if (d > 26) d = 26;
      kept = sig >> d;
      rem  = sig & ((longint'(1) << d) - 1);
      half = longint'(1) << (d - 1);
      case (rm)                                                    // R7
        2'd0: up = (rem > half) || (rem == half && kept[0]);
        2'd1: up = !s && rem != 0;
        2'd2: up = s && rem != 0;
        default: up = 0;
      endcase
      inx = (rem != 0);                                            // R12
      kept = kept + (up ? 1 : 0);
      if (e >= 113) begin
        eh = int'(e) - 112;
        if (kept == 2048) begin eh = eh + 1; kept = 1024; tag = 8; end  // R8
        else tag = inx ? 7 : 1;
        fr = int'(kept) - 1024;
      end else begin
        tag = 6;
        if (kept == 1024) begin eh = 1; fr = 0; tag = 8; end
        else begin eh = 0; fr = int'(kept); end
      end
      if (alt && eh >= 32) begin                                   // R10
        r = {s, 15'h7FFF}; inv = 1; inx = 0; tag = 10;
      end else if (!alt && eh >= 31) begin                         // R9
        ovf = 1; inx = 1; tag = 9;
        r = (rm == 2'd0 || (rm == 2'd1 && !s) || (rm == 2'd2 && s))
            ? {s, 15'h7C00} : {s, 15'h7BFF};
      end else begin
        r = {s, eh[4:0], fr[9:0]};
        unf = (eh == 0) && (inx || ut);                            // R11
        if (eh == 0 && tag == 6 && unf) tag = 11;
      end
    end
    expv = {r, inv, ovf, unf, inx};
  endtask

  task automatic check(input int tag, input logic [19:0] expv);
    logic [19:0] act;
    act = {resOut, flgInvalid, flgOverflow, flgUnderflow, flgInexact};
    checks++;
    if (act !== expv) begin
      errors++;
      if (errors < 30)
        $display("FAIL R%0d op=%h rm=%0d alt=%0b actual=%h expected=%h",
                 tag, opIn, rndMode, altFmt, act, expv);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] expv;
    int tag;
    logic [22:0] pats [12];
    pats = '{23'h000000, 23'h000001, 23'h001000, 23'h001001, 23'h002000, 23'h003000,
             23'h7FE000, 23'h7FFFFF, 23'h400000, 23'h001FFF, 23'h123456, 23'h7FF000};
    repeat (3) @(posedge clk);
    #2;
    check(14, 20'h0);                       // R14 reset clears outputs
    rst = 1'b0;
    @(posedge clk); #2;
    check(14, 20'h0);                       // zero operand after reset
    opIn = 32'h3F800000;                    // 1.0
    #2;
    check(14, 20'h0);                       // R14 not visible before the edge
    @(posedge clk); #2;
    check(14, {16'h3C00, 4'b0000});         // R14 one-cycle latency

    for (int a = 0; a < 2; a++)
      for (int rm = 0; rm < 4; rm++)
        for (int sg = 0; sg < 2; sg++)
          for (int p = 0; p < 12; p++)
            for (int e = 0; e < 256; e++) begin
              opIn     = {sg[0], e[7:0], pats[p]};
              rndMode  = rm[1:0];
              altFmt   = a[0];
              flushEn  = p[0] ^ e[0];
              dnanEn   = p[1] ^ e[1];
              ufTrapEn = e[2] ^ sg[0];
              model(opIn, rndMode, altFmt, flushEn, dnanEn, ufTrapEn, expv, tag);
              @(posedge clk); #2;
              check(tag, expv);
            end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule